// File: doc/BRIEF.md
# Aliased Scalar/Vector Register File

This block holds 32 registers of 256 bits each and exposes them through three nested views selected by a 2-bit width code: a 64-bit scalar floating-point view, a 128-bit short-vector view and a 256-bit long-vector view. View n of every width maps onto the same physical entry n. The scalar register is the low 64 bits of that entry. The short-vector register is its low 128 bits. A write through any view is therefore visible through the other two. The storage is organised as four 64-bit lanes, and each view touches lanes 0 upward: one lane for scalar, two for short, four for long.

There is one read port and one write port, and each carries its own width code and 5-bit index. Reads are registered and appear one clock after the request. When a read and a write address the same index in the same cycle, the read sees the new data in the lanes both accesses cover. Two enable inputs gate the short-vector and long-vector views. An access through a gated view, or through the reserved width code, is refused. A refused access touches nothing and raises a one-cycle flag.

Top module: `vreg_alias_file`

## Requirements
- R1: After reset every entry reads as zero through every view, and rdData, rdValid, rdDenied and wrDenied are all low.
- R2: A scalar read (rdView = 0) returns the entry's bits [63:0] in rdData[63:0], with rdData[255:64] zero. A short read (rdView = 1) returns bits [127:0] with rdData[255:128] zero.
- R3: Width code 0 is scalar, 1 is short-vector, 2 is long-vector and 3 is reserved. Any read or write with code 3 is refused.
- R4: A write through a narrower view changes only its own low slice (64 or 128 bits) and leaves the upper bits of the entry unchanged.
- R5: A long-vector write to entry n is visible in the low 128 bits through a short read of n, and in the low 64 bits through a scalar read of n.
- R6: A read accepted at clock edge k drives rdData and rdValid = 1 in the cycle after edge k. Without an accepted read, rdValid is low in that cycle.
- R7: If an accepted read and an accepted write name the same index at the same edge, the read returns the write data in the lanes both views cover, and the previously stored data in the remaining lanes the read covers.
- R8: With shortVecEn low, a short-view read returns zero with rdValid low and rdDenied high for one cycle. A short-view write is dropped, leaves the entry unchanged, and raises wrDenied for one cycle.
- R9: The long view is gated only by longVecEn and the short view only by shortVecEn. The scalar view is never refused.
- R10: A refused write does not bypass into a same-cycle read of the same index.
- R11: rdData is zero in every cycle where rdValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| shortVecEn | input | 1 | Enables the 128-bit view |
| longVecEn | input | 1 | Enables the 256-bit view |
| rdReq | input | 1 | Read request |
| rdView | input | 2 | Read width code |
| rdIdx | input | 5 | Read register index |
| wrReq | input | 1 | Write request |
| wrView | input | 2 | Write width code |
| wrIdx | input | 5 | Write register index |
| wrData | input | 256 | Write data; a narrow view uses the low bits |
| rdData | output | 256 | Registered read data, zero-extended |
| rdValid | output | 1 | A read was accepted at the previous edge |
| rdDenied | output | 1 | A read was refused at the previous edge |
| wrDenied | output | 1 | A write was refused at the previous edge |

## Verification
The bench targets three kinds of fault. The first is collisions where a narrow write meets a wider same-index read, or the reverse. A wrong lane mask there either leaks new data into lanes the write never covered or returns stale data in covered lanes. The second is narrow writes followed by long reads: a design that clears or overwrites the upper lanes shows a mismatch in bits above 64 or 128. The third is refused accesses, including the reserved code, a gated view with the other enable high, and a refused write colliding with a read. A design that lets any of these touch the array or the bypass shows changed data or missing flags.

// File: rtl/vreg_alias_pkg.sv
package vreg_alias_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    VIEW_SCALAR = 2'd0,
    VIEW_SHORT  = 2'd1,
    VIEW_LONG   = 2'd2,
    VIEW_RSVD   = 2'd3
  } view_e;

  typedef struct packed {
    logic             wrGo;
    logic [LANES-1:0] wrLanes;
    logic             rdGo;
    logic [LANES-1:0] rdLanes;
    logic [LANES-1:0] bypassLanes;
    logic             rdDeny;
    logic             wrDeny;
  } rfStrobe_t;

  function automatic logic [LANES-1:0] viewLanes(input view_e v);
    case (v)
      VIEW_SCALAR: viewLanes = 4'b0001;
      VIEW_SHORT:  viewLanes = 4'b0011;
      VIEW_LONG:   viewLanes = 4'b1111;
      default:     viewLanes = 4'b0000;
    endcase
  endfunction

  function automatic logic viewOpen(input view_e v, input logic shortEn, input logic longEn);
    case (v)
      VIEW_SCALAR: viewOpen = 1'b1;
      VIEW_SHORT:  viewOpen = shortEn;
      VIEW_LONG:   viewOpen = longEn;
      default:     viewOpen = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/vreg_alias_ctrl.sv
module vreg_alias_ctrl
  import vreg_alias_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             shortVecEn,
  input  logic             longVecEn,
  input  logic             rdReq,
  input  logic [1:0]       rdView,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic             wrReq,
  input  logic [1:0]       wrView,
  input  logic [IDX_W-1:0] wrIdx,
  output rfStrobe_t        strobe
);
  logic rdOpen, wrOpen, rdOk, wrOk, sameIdx;
  logic [LANES-1:0] rdMaskRaw, wrMaskRaw;

  always_comb begin
    rdOpen    = viewOpen(view_e'(rdView), shortVecEn, longVecEn);
    wrOpen    = viewOpen(view_e'(wrView), shortVecEn, longVecEn);
    rdMaskRaw = viewLanes(view_e'(rdView));
    wrMaskRaw = viewLanes(view_e'(wrView));
    rdOk      = rdReq && rdOpen;
    wrOk      = wrReq && wrOpen;
    sameIdx   = (rdIdx == wrIdx);

    strobe.rdGo    = rdOk;
    strobe.wrGo    = wrOk;
    strobe.rdLanes = rdOk ? rdMaskRaw : '0;
    strobe.wrLanes = wrOk ? wrMaskRaw : '0;
    strobe.rdDeny  = rdReq && !rdOpen;
    strobe.wrDeny  = wrReq && !wrOpen;
    for (int l = 0; l < LANES; l++) begin
      strobe.bypassLanes[l] = sameIdx && rdOk && wrOk && rdMaskRaw[l] && wrMaskRaw[l];
    end
  end
endmodule

// File: rtl/vreg_alias_dp.sv
module vreg_alias_dp
  import vreg_alias_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int LANE_W   = 64,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int FULL_W  = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobe_t         strobe,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [FULL_W-1:0] wrData,
  output logic [FULL_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdDenied,
  output logic              wrDenied
);
  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [LANE_W-1:0] bankQ [NUM_REGS];
    logic [LANE_W-1:0] wrSlice, rdNext, rdLaneQ;

    assign wrSlice = wrData[l*LANE_W +: LANE_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int r = 0; r < NUM_REGS; r++) bankQ[r] <= '0;
      end else if (strobe.wrGo && strobe.wrLanes[l]) begin
        bankQ[wrIdx] <= wrSlice;
      end
    end

    always_comb begin
      if (!strobe.rdLanes[l])          rdNext = '0;
      else if (strobe.bypassLanes[l])  rdNext = wrSlice;
      else                             rdNext = bankQ[rdIdx];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rdLaneQ <= '0;
      else       rdLaneQ <= rdNext;
    end

    assign rdData[l*LANE_W +: LANE_W] = rdLaneQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      rdDenied <= 1'b0;
      wrDenied <= 1'b0;
    end else begin
      rdValid  <= strobe.rdGo;
      rdDenied <= strobe.rdDeny;
      wrDenied <= strobe.wrDeny;
    end
  end
endmodule

// File: rtl/vreg_alias_file.sv
module vreg_alias_file
  import vreg_alias_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int LANE_W   = 64,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int FULL_W  = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shortVecEn,
  input  logic              longVecEn,
  input  logic              rdReq,
  input  logic [1:0]        rdView,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic              wrReq,
  input  logic [1:0]        wrView,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [FULL_W-1:0] wrData,
  output logic [FULL_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdDenied,
  output logic              wrDenied
);
  rfStrobe_t strobe;

  vreg_alias_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .shortVecEn(shortVecEn), .longVecEn(longVecEn),
    .rdReq(rdReq), .rdView(rdView), .rdIdx(rdIdx),
    .wrReq(wrReq), .wrView(wrView), .wrIdx(wrIdx),
    .strobe(strobe)
  );

  vreg_alias_dp #(.NUM_REGS(NUM_REGS), .LANE_W(LANE_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdIdx(rdIdx), .wrIdx(wrIdx), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid),
    .rdDenied(rdDenied), .wrDenied(wrDenied)
  );
endmodule

// File: rtl/vreg_alias_check.sv
module vreg_alias_check #(
  parameter int IDX_W  = 5,
  parameter int LANE_W = 64,
  parameter int FULL_W = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              shortVecEn,
  input logic              longVecEn,
  input logic              rdReq,
  input logic [1:0]        rdView,
  input logic [IDX_W-1:0]  rdIdx,
  input logic              wrReq,
  input logic [1:0]        wrView,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [FULL_W-1:0] wrData,
  input logic [FULL_W-1:0] rdData,
  input logic              rdValid,
  input logic              rdDenied,
  input logic              wrDenied
);
  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> rdData == '0);

  assert_scalar_zext_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdView == 2'd0) |=> (rdValid && rdData[FULL_W-1:LANE_W] == '0));

  assert_reserved_refused_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdView == 2'd3) |=> (rdDenied && !rdValid));

  assert_short_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrView == 2'd1 && !shortVecEn) |=> wrDenied);

  assert_deny_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdDenied |-> !rdValid);

  assert_scalar_open_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrView == 2'd0) |=> !wrDenied);

  assert_long_open_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdView == 2'd2 && longVecEn) |=> rdValid);

  assert_full_bypass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && wrReq && rdIdx == wrIdx && rdView == 2'd2 && wrView == 2'd2 && longVecEn)
      |=> rdData == $past(wrData));
endmodule

bind vreg_alias_file vreg_alias_check #(.IDX_W(IDX_W), .LANE_W(LANE_W), .FULL_W(FULL_W)) uCheck (
  .clk(clk), .rstN(rstN), .shortVecEn(shortVecEn), .longVecEn(longVecEn),
  .rdReq(rdReq), .rdView(rdView), .rdIdx(rdIdx),
  .wrReq(wrReq), .wrView(wrView), .wrIdx(wrIdx), .wrData(wrData),
  .rdData(rdData), .rdValid(rdValid), .rdDenied(rdDenied), .wrDenied(wrDenied)
);

// File: tb/vreg_alias_file_test.sv
`timescale 1ns/1ps
module vreg_alias_file_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shortVecEn = 1'b1, longVecEn = 1'b1;
  logic rdReq = 1'b0, wrReq = 1'b0;
  logic [1:0] rdView = 2'd0, wrView = 2'd0;
  logic [4:0] rdIdx = '0, wrIdx = '0;
  logic [255:0] wrData = '0;
  logic [255:0] rdData;
  logic rdValid, rdDenied, wrDenied;

  int checks = 0;
  int failures = 0;
  logic [255:0] model [32];

  always #2.5 clk = ~clk;

  vreg_alias_file uut (
    .clk(clk), .rstN(rstN), .shortVecEn(shortVecEn), .longVecEn(longVecEn),
    .rdReq(rdReq), .rdView(rdView), .rdIdx(rdIdx),
    .wrReq(wrReq), .wrView(wrView), .wrIdx(wrIdx), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .rdDenied(rdDenied), .wrDenied(wrDenied)
  );

  function automatic logic [255:0] bitMask(input logic [1:0] v);
    case (v)
      2'd0: bitMask = {192'd0, {64{1'b1}}};
      2'd1: bitMask = {128'd0, {128{1'b1}}};
      2'd2: bitMask = {256{1'b1}};
      default: bitMask = '0;
    endcase
  endfunction

  function automatic bit opened(input logic [1:0] v, input logic sEn, input logic lEn);
    case (v)
      2'd0: opened = 1'b1;
      2'd1: opened = sEn;
      2'd2: opened = lEn;
      default: opened = 1'b0;
    endcase
  endfunction

  function automatic logic [255:0] rand256();
    logic [255:0] x;
    for (int i = 0; i < 8; i++) x[i*32 +: 32] = $urandom;
    return x;
  endfunction

  task automatic compare(input string tag, input logic [255:0] expD, input bit expV,
                         input bit expRd, input bit expWd);
    checks++;
    if (rdData !== expD || rdValid !== expV || rdDenied !== expRd || wrDenied !== expWd) begin
      failures++;
      $display("FAIL %s: data=%h valid=%b rdDen=%b wrDen=%b expected data=%h valid=%b rdDen=%b wrDen=%b",
               tag, rdData, rdValid, rdDenied, wrDenied, expD, expV, expRd, expWd);
    end
  endtask

  // Called at a falling edge; drives one request cycle and checks the result after the next rising edge.
  task automatic step(input bit rq, input logic [1:0] rv, input int ri,
                      input bit wq, input logic [1:0] wv, input int wi,
                      input logic [255:0] wd, input string tag);
    bit rOk, wOk;
    logic [255:0] cur, expD;
    rOk = rq && opened(rv, shortVecEn, longVecEn);
    wOk = wq && opened(wv, shortVecEn, longVecEn);
    expD = '0;
    if (rOk) begin
      cur = model[ri];
      if (wOk && wi == ri) cur = (cur & ~bitMask(wv)) | (wd & bitMask(wv));
      expD = cur & bitMask(rv);
    end
    if (wOk) model[wi] = (model[wi] & ~bitMask(wv)) | (wd & bitMask(wv));
    rdReq = rq; rdView = rv; rdIdx = 5'(ri);
    wrReq = wq; wrView = wv; wrIdx = 5'(wi); wrData = wd;
    @(posedge clk);
    @(negedge clk);
    rdReq = 1'b0; wrReq = 1'b0;
    compare(tag, expD, rOk, rq && !rOk, wq && !wOk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [255:0] a, b;
    void'($urandom(32'h1d2c3b4a));
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 reset outputs", '0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 32; i++) step(1, 2'd2, i, 0, 2'd0, 0, '0, "R1 long read after reset");
    step(1, 2'd0, 7, 0, 2'd0, 0, '0, "R1 scalar read after reset");

    // R5: long write seen through narrow views
    a = rand256();
    step(0, 2'd0, 0, 1, 2'd2, 5, a, "R5 long write");
    step(1, 2'd1, 5, 0, 2'd0, 0, '0, "R5 R2 short read of long data");
    step(1, 2'd0, 5, 0, 2'd0, 0, '0, "R5 R2 scalar read of long data");
    // R4: narrow writes keep upper bits
    b = rand256();
    step(0, 2'd0, 0, 1, 2'd0, 5, b, "R4 scalar write");
    step(1, 2'd2, 5, 0, 2'd0, 0, '0, "R4 upper bits kept after scalar write");
    b = rand256();
    step(0, 2'd0, 0, 1, 2'd1, 5, b, "R4 short write");
    step(1, 2'd2, 5, 0, 2'd0, 0, '0, "R4 upper bits kept after short write");
    // R7: collisions of different widths
    step(1, 2'd2, 5, 1, 2'd0, 5, rand256(), "R7 scalar write vs long read");
    step(1, 2'd0, 5, 1, 2'd2, 5, rand256(), "R7 long write vs scalar read");
    step(1, 2'd1, 5, 1, 2'd1, 5, rand256(), "R7 short write vs short read");
    step(1, 2'd2, 5, 1, 2'd2, 6, rand256(), "R7 different index no bypass");
    // R3: reserved code
    step(1, 2'd3, 5, 1, 2'd3, 5, rand256(), "R3 reserved code refused");
    step(1, 2'd2, 5, 0, 2'd0, 0, '0, "R3 entry unchanged after reserved write");
    // R8 / R10: short view gated
    shortVecEn = 1'b0;
    step(1, 2'd1, 5, 1, 2'd1, 5, rand256(), "R8 R10 short gated read and write");
    step(1, 2'd2, 5, 0, 2'd0, 0, '0, "R9 long open while short gated");
    step(1, 2'd0, 5, 1, 2'd0, 5, rand256(), "R9 scalar open while short gated");
    shortVecEn = 1'b1; longVecEn = 1'b0;
    step(1, 2'd2, 5, 1, 2'd2, 5, rand256(), "R9 R10 long gated");
    step(1, 2'd1, 5, 0, 2'd0, 0, '0, "R9 short open while long gated");
    step(1, 2'd2, 5, 1, 2'd1, 5, rand256(), "R10 refused read with open write");
    longVecEn = 1'b1;
    step(1, 2'd2, 5, 0, 2'd0, 0, '0, "R8 entry unchanged after gated writes");

    // Random mix with a narrow index range to force collisions
    for (int n = 0; n < 4000; n++) begin
      bit rq, wq;
      logic [1:0] rv, wv;
      int ri, wi;
      shortVecEn = ($urandom % 8) != 0;
      longVecEn  = ($urandom % 8) != 0;
      rq = $urandom % 4 != 0;
      wq = $urandom % 2 != 0;
      rv = 2'($urandom % 4);
      wv = 2'($urandom % 4);
      ri = $urandom % 4;
      wi = $urandom % 4;
      if (rq && wq && ri == wi) step(rq, rv, ri, wq, wv, wi, rand256(), "R7 random collision");
      else step(rq, rv, ri, wq, wv, wi, rand256(), "R6 R11 random access");
    end
    shortVecEn = 1'b1; longVecEn = 1'b1;
    for (int i = 0; i < 4; i++) step(1, 2'd2, i, 0, 2'd0, 0, '0, "R4 R5 final contents");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule